// File: doc/BRIEF.md
# Cascaded Split-Stage Compare Timer

This block is a compare timer made of two counter stages: a 4-bit low stage and an 8-bit high stage. In cascade mode the low stage counts input clocks and its overflow advances the high stage, so the pair acts as one 12-bit counter. Either stage can also run on its own, counting input clocks against its own compare value. When the count equals the compare value, the block can clear the counter, invert an output flip-flop and pulse an interrupt. Each of these three actions has its own enable. Each time the low stage overflows by counting, a divided-clock pulse comes out.

Software programs the block through a write-only port with four addresses. Compare values are held in pending registers. They are copied into the active compare registers only when the counter returns to zero, so a value that is only half written can never cause a false match. A control block built as a state machine governs the timer. Its states are IDLE (stopped, counts held), CASC (12-bit cascade), LOW (4-bit stage alone) and HIGH (8-bit stage alone). A start write moves the machine from any state into CASC, LOW or HIGH, chosen by the mode field, and clears both stages. A stop write moves the machine from any state into IDLE.

Top module: `split_timer`

## Requirements
- R1: Address 0 is control: bit 0 is run, bits 2:1 are mode (0 cascade, 1 low stage alone, 2 high stage alone, 3 behaves as cascade). Address 1 holds the actions: bit 0 clears the counter on match, bit 1 inverts the toggle output on match, bit 2 pulses the interrupt on match. An action write is used from the next clock edge. Address 2 holds the low compare in bits 3:0. Address 3 holds the high compare in bits 7:0.
- R2: A control write with bit 0 set clears both stages at that edge and enters the chosen run state, even when the timer is already running. The count is then 1 after the following edge.
- R3: A control write with bit 0 clear enters IDLE. While in IDLE both stages hold their value, and no interrupt, toggle or divided-clock pulse occurs.
- R4: In cascade mode a match needs the low stage to equal the low compare and the high stage to equal the high compare in the same cycle. With clear-on-match enabled, matches repeat every V+1 clocks, where V = high*16 + low.
- R5: With a single stage selected and clear-on-match enabled, matches repeat every v+1 clocks, where v is that stage's own compare value.
- R6: With clear-on-match disabled, the counter wraps freely: 4095 to 0 in cascade mode, 15 to 0 in low mode and 255 to 0 in high mode. There is one match per full pass.
- R7: With the interrupt enabled, irq_out is high for exactly the one cycle after each clock edge at which the count equaled the active compare.
- R8: tog_out is low after reset. It inverts once per match while the toggle action is enabled, and a start write does not change it.
- R9: tick_out pulses for one cycle after each edge at which the low stage counts from 15 to 0 (cascade and low modes). It stays low in high mode, and stays low when the low stage is cleared instead of counting.
- R10: Compare writes change only the pending values. The active compare is replaced only when the count returns to zero: at a start write, at a clear on match, or at a free wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock; counts this clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address |
| wr_data | input | 8 | Register write data |
| tick_out | output | 1 | Low-stage overflow pulse (input clock divided by 16 when free running) |
| tog_out | output | 1 | Toggle flip-flop output |
| irq_out | output | 1 | One-cycle match interrupt |

## Verification
The hardest case to reach is a compare write that lands in the middle of a count pass. The old value must still produce the next match, and the new value must take over only after the counter returns to zero. The stimulus gets there with a directed cascade run: it starts the timer, writes only the low compare part-way through the pass, and then runs through two further periods. Free 4096-clock cascade wraps and a cascade compare of 4095 are driven on purpose, because random compare values rarely produce them. Random runs add irregular mixes of modes and action enables on top of these cases.

// File: rtl/split_timer_pkg.sv
package split_timer_pkg;

    typedef enum logic [1:0] {
        MODE_CASC = 2'd0,
        MODE_LOW  = 2'd1,
        MODE_HIGH = 2'd2,
        MODE_RSVD = 2'd3
    } mode_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CASC = 2'd1,
        ST_LOW  = 2'd2,
        ST_HIGH = 2'd3
    } run_state_e;

    localparam logic [1:0] ADDR_CTRL   = 2'd0;
    localparam logic [1:0] ADDR_ACT    = 2'd1;
    localparam logic [1:0] ADDR_CMP_LO = 2'd2;
    localparam logic [1:0] ADDR_CMP_HI = 2'd3;

    localparam int BIT_RUN = 0;

    typedef struct packed {
        logic irq;
        logic tog;
        logic clr;
    } act_t;

endpackage

// File: rtl/split_timer_regs.sv
module split_timer_regs
    import split_timer_pkg::*;
#(
    parameter int LO_W   = 4,
    parameter int HI_W   = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              load_cmp,
    output logic              start_req,
    output logic              stop_req,
    output mode_e             mode_req,
    output act_t              act,
    output logic [LO_W-1:0]   cmp_lo,
    output logic [HI_W-1:0]   cmp_hi
);

    logic [LO_W-1:0] pend_lo;
    logic [HI_W-1:0] pend_hi;
    logic            ctrl_wr;
    logic            unused_hi_bits;

    assign ctrl_wr        = wr_en && (wr_addr == ADDR_CTRL);
    assign start_req      = ctrl_wr && wr_data[BIT_RUN];
    assign stop_req       = ctrl_wr && !wr_data[BIT_RUN];
    assign mode_req       = mode_e'(wr_data[2:1]);
    assign unused_hi_bits = ^wr_data;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act     <= '0;
            pend_lo <= '0;
            pend_hi <= '0;
        end else if (wr_en) begin
            unique case (wr_addr)
                ADDR_ACT:    act     <= act_t'(wr_data[2:0]);
                ADDR_CMP_LO: pend_lo <= wr_data[LO_W-1:0];
                ADDR_CMP_HI: pend_hi <= wr_data[HI_W-1:0];
                default:     ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_lo <= '0;
            cmp_hi <= '0;
        end else if (load_cmp) begin
            cmp_lo <= pend_lo;
            cmp_hi <= pend_hi;
        end
    end

    assert_cmp_reload_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(load_cmp) |-> ($stable(cmp_lo) && $stable(cmp_hi)))
        else $error("active compare changed without a reload");

endmodule

// File: rtl/split_timer_stage.sv
module split_timer_stage #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt,
    output logic         carry
);

    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    assign carry = inc && !clr && (&cnt);

    always_ff @(posedge clk) begin
        if (!rst_n)   cnt <= '0;
        else if (clr) cnt <= '0;
        else if (inc) cnt <= cnt + ONE;
    end

    assert_stage_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(clr) |-> (cnt == '0))
        else $error("stage not zero after clear");

endmodule

// File: rtl/split_timer_ctrl.sv
module split_timer_ctrl
    import split_timer_pkg::*;
#(
    parameter int LO_W = 4,
    parameter int HI_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_req,
    input  logic            stop_req,
    input  mode_e           mode_req,
    input  act_t            act,
    input  logic [LO_W-1:0] lo_cnt,
    input  logic [HI_W-1:0] hi_cnt,
    input  logic [LO_W-1:0] cmp_lo,
    input  logic [HI_W-1:0] cmp_hi,
    input  logic            lo_carry,
    input  logic            hi_carry,
    output logic            inc_lo,
    output logic            inc_hi,
    output logic            clr_cnt,
    output logic            load_cmp,
    output logic            irq_out,
    output logic            tog_out,
    output logic            tick_out
);

    run_state_e state, next_state;
    logic       match;
    logic       match_clr;
    logic       pass_end;

    // next-state selection
    always_comb begin
        next_state = state;
        if (start_req) begin
            unique case (mode_req)
                MODE_LOW:  next_state = ST_LOW;
                MODE_HIGH: next_state = ST_HIGH;
                default:   next_state = ST_CASC;
            endcase
        end else if (stop_req) begin
            next_state = ST_IDLE;
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= next_state;
    end

    // per-state compare and stage stepping
    always_comb begin
        match  = 1'b0;
        inc_lo = 1'b0;
        inc_hi = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_CASC: begin
                match  = (lo_cnt == cmp_lo) && (hi_cnt == cmp_hi);
                inc_lo = 1'b1;
                inc_hi = lo_carry;
            end
            ST_LOW: begin
                match  = (lo_cnt == cmp_lo);
                inc_lo = 1'b1;
            end
            ST_HIGH: begin
                match  = (hi_cnt == cmp_hi);
                inc_hi = 1'b1;
            end
        endcase
    end

    assign match_clr = match && act.clr;
    assign pass_end  = (state == ST_LOW) ? lo_carry : hi_carry;
    assign clr_cnt   = start_req || match_clr;
    assign load_cmp  = start_req || match_clr || pass_end;

    // event outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_out  <= 1'b0;
            tog_out  <= 1'b0;
            tick_out <= 1'b0;
        end else begin
            irq_out  <= match && act.irq;
            tick_out <= lo_carry;
            if (match && act.tog) tog_out <= !tog_out;
        end
    end

    assert_irq_only_running_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> $past(state != ST_IDLE))
        else $error("interrupt raised while stopped");

    assert_tog_on_match_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (tog_out != $past(tog_out)) |-> $past(match && act.tog))
        else $error("toggle changed without an enabled match");

    assert_tick_low_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        tick_out |-> ((lo_cnt == '0) && $past(state == ST_CASC || state == ST_LOW)))
        else $error("tick without a low-stage wrap");

    assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state == ST_IDLE) && !$past(start_req)) |-> ($stable(lo_cnt) && $stable(hi_cnt)))
        else $error("count moved while stopped");

    assert_match_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(match_clr) |-> ((lo_cnt == '0) && (hi_cnt == '0)))
        else $error("counter not cleared after match");

endmodule

// File: rtl/split_timer.sv
module split_timer
    import split_timer_pkg::*;
#(
    parameter int LO_W   = 4,
    parameter int HI_W   = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              tick_out,
    output logic              tog_out,
    output logic              irq_out
);

    logic            start_req, stop_req;
    mode_e           mode_req;
    act_t            act;
    logic [LO_W-1:0] cmp_lo, lo_cnt;
    logic [HI_W-1:0] cmp_hi, hi_cnt;
    logic            inc_lo, inc_hi, clr_cnt, load_cmp;
    logic            lo_carry, hi_carry;

    split_timer_regs #(.LO_W(LO_W), .HI_W(HI_W), .DATA_W(DATA_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .load_cmp  (load_cmp),
        .start_req (start_req),
        .stop_req  (stop_req),
        .mode_req  (mode_req),
        .act       (act),
        .cmp_lo    (cmp_lo),
        .cmp_hi    (cmp_hi)
    );

    split_timer_stage #(.W(LO_W)) u_lo (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr_cnt),
        .inc   (inc_lo),
        .cnt   (lo_cnt),
        .carry (lo_carry)
    );

    split_timer_stage #(.W(HI_W)) u_hi (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr_cnt),
        .inc   (inc_hi),
        .cnt   (hi_cnt),
        .carry (hi_carry)
    );

    split_timer_ctrl #(.LO_W(LO_W), .HI_W(HI_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_req (start_req),
        .stop_req  (stop_req),
        .mode_req  (mode_req),
        .act       (act),
        .lo_cnt    (lo_cnt),
        .hi_cnt    (hi_cnt),
        .cmp_lo    (cmp_lo),
        .cmp_hi    (cmp_hi),
        .lo_carry  (lo_carry),
        .hi_carry  (hi_carry),
        .inc_lo    (inc_lo),
        .inc_hi    (inc_hi),
        .clr_cnt   (clr_cnt),
        .load_cmp  (load_cmp),
        .irq_out   (irq_out),
        .tog_out   (tog_out),
        .tick_out  (tick_out)
    );

endmodule

// File: tb/split_timer_test.sv
module split_timer_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic       tick_out, tog_out, irq_out;

    int    checks = 0;
    int    errors = 0;
    bit    done = 1'b0;
    string scen = "R8 reset";

    // reference state built from the requirements
    bit m_run, m_tog, m_irq, m_tick;
    int m_mode, m_act, m_pos, m_vlo, m_vhi, m_plo, m_phi;

    always #4 clk = ~clk;

    split_timer uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .tick_out (tick_out),
        .tog_out  (tog_out),
        .irq_out  (irq_out)
    );

    function automatic int period_of(input int mode);
        return (mode == 1) ? 16 : (mode == 2) ? 256 : 4096;
    endfunction

    function automatic int target_of(input int mode, input int vlo, input int vhi);
        return (mode == 1) ? vlo : (mode == 2) ? vhi : vhi * 16 + vlo;
    endfunction

    function automatic int mode_of(input logic [7:0] d);
        return (d[2:1] == 2'd3) ? 0 : int'(d[2:1]);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_run = 0; m_tog = 0; m_irq = 0; m_tick = 0;
            m_mode = 0; m_act = 0; m_pos = 0;
            m_vlo = 0; m_vhi = 0; m_plo = 0; m_phi = 0;
        end else begin
            bit start, stop, match, reload;
            start  = wr_en && wr_addr == 2'd0 && wr_data[0];
            stop   = wr_en && wr_addr == 2'd0 && !wr_data[0];
            match  = m_run && (m_pos == target_of(m_mode, m_vlo, m_vhi));
            reload = 0;
            m_irq  = match && m_act[2];
            if (match && m_act[1]) m_tog = !m_tog;
            m_tick = m_run && m_mode != 2 && (m_pos % 16 == 15)
                     && !(match && m_act[0]) && !start;
            if (start) begin
                m_pos = 0; reload = 1;
            end else if (m_run) begin
                if (match && m_act[0]) begin
                    m_pos = 0; reload = 1;
                end else begin
                    m_pos = (m_pos + 1) % period_of(m_mode);
                    if (m_pos == 0) reload = 1;
                end
            end
            if (reload) begin m_vlo = m_plo; m_vhi = m_phi; end
            if (start) begin m_run = 1; m_mode = mode_of(wr_data); end
            if (stop) m_run = 0;
            if (wr_en && wr_addr == 2'd1) m_act = int'(wr_data[2:0]);
            if (wr_en && wr_addr == 2'd2) m_plo = int'(wr_data[3:0]);
            if (wr_en && wr_addr == 2'd3) m_phi = int'(wr_data);
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(irq_out == m_irq, {scen, " R7 irq"}, int'(irq_out), int'(m_irq));
            chk(tog_out == m_tog, {scen, " R8 tog"}, int'(tog_out), int'(m_tog));
            chk(tick_out == m_tick, {scen, " R9 tick"}, int'(tick_out), int'(m_tick));
        end
    end

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic setup(input int act, input int lo, input int hi, input int mode);
        wr(2'd1, 8'(act));
        wr(2'd2, 8'(lo));
        wr(2'd3, 8'(hi));
        wr(2'd0, 8'((mode << 1) | 1));
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R8: reset state
        chk(tog_out == 1'b0, "R8 tog after reset", int'(tog_out), 0);
        chk(irq_out == 1'b0, "R7 irq after reset", int'(irq_out), 0);
        chk(tick_out == 1'b0, "R9 tick after reset", int'(tick_out), 0);

        scen = "R1 R2 R4 cascade";
        setup(7, 3, 8'h12, 0);
        run(300);
        scen = "R10 mid-pass compare write";
        wr(2'd2, 8'h5);
        run(700);

        scen = "R4 cascade compare zero";
        setup(5, 0, 0, 0);
        run(20);

        scen = "R3 stopped";
        wr(2'd0, 8'h00);
        run(150);
        scen = "R2 restart";
        wr(2'd0, 8'h01);
        run(60);

        scen = "R5 low stage at 15";
        setup(7, 15, 0, 1);
        run(70);
        scen = "R5 high stage";
        setup(7, 9, 8'd40, 2);
        run(100);

        scen = "R6 free cascade";
        setup(6, 4, 8'h0F, 0);
        run(8300);
        scen = "R6 free low";
        setup(6, 7, 0, 1);
        run(60);

        scen = "R4 cascade max";
        setup(7, 15, 8'hFF, 0);
        run(8300);

        scen = "R1 reserved mode";
        setup(7, 2, 1, 3);
        run(60);

        for (int i = 0; i < 12; i++) begin
            int mode, act, lo, hi, len, v;
            mode = $urandom % 4;
            act  = $urandom % 8;
            lo   = $urandom % 16;
            hi   = $urandom % 256;
            if (mode == 0 || mode == 3) hi = hi % 64;
            v = target_of(mode_of(8'(mode << 1)), lo, hi);
            if (act[0]) len = 2 * (v + 1) + 20;
            else len = 2 * period_of(mode_of(8'(mode << 1))) + 20;
            scen = "R1 R5 R6 random";
            setup(act, lo, hi, mode);
            run(len / 2);
            wr(2'd1, 8'($urandom % 8));
            run(len / 2);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule